// File: doc/BRIEF.md
# Burst Column Sequencer with Mode Register

This block keeps the operating mode of a synchronous DRAM column path and turns one column command into a stream of column addresses. A mode-load strobe captures burst length, ordering, CAS latency and a single-write option from the address bus. Encodings that are not allowed are rejected: the error output goes high and the stored mode stays as it was. CAS latency is only stored and driven out; the data path and latency pipeline are outside the block.

A read or write command with a start column puts the block into one of three states. `IDLE` means no burst. `FIXED` runs a burst of 1, 2, 4 or 8 beats. `PAGE` runs a full-page burst that never ends by itself. Every state has the transition *command*, which goes to `FIXED` or `PAGE` and restarts at the new column. `FIXED` goes to `IDLE` through *final beat* or *stop*. `PAGE` goes to `IDLE` through *stop* only. Each beat gives one column, a valid flag, and a last flag on the final beat of a fixed burst. The burst keeps the length and ordering it had when its command was taken.

Top module: `sdr_burst_colgen`

## Requirements
- R1: After reset, `col_valid`, `col_last` and `mode_err` are low. The stored mode is burst length 1, sequential, CAS latency 2 (`cas_lat`=3'b010), single-write off. A read issued straight after reset gives one beat, flagged last.
- R2: A cycle with `mrs_stb` high loads the mode from `mrs_addr`, and the new values apply from the next cycle. Bits [2:0] set burst length: 000=1, 001=2, 010=4, 011=8, 111=full page. Bit 3 sets order: 0 sequential, 1 interleave. Bits [6:4] set CAS latency, which appears on `cas_lat`. Bit 9 is the single-write option.
- R3: Some loads are reserved. These are burst length 100 to 110, CAS latency other than 010 or 011, bits [8:7] not 00, and any bit above 9 set. A reserved load sets `mode_err` high from the next cycle and keeps the previous mode. A valid load clears `mode_err`.
- R4: A `rd_cmd` or `wr_cmd` sampled at a clock edge gives beat 0 with `col_valid` high in the following cycle. Beat 0 equals `start_col`. After that, one beat follows per cycle.
- R5: In sequential order with fixed length L, beat k keeps the bits of `start_col` above log2(L). Its low log2(L) bits are (start + k) mod L, so the column wraps inside the aligned block.
- R6: In interleave order with fixed length L, beat k is `start_col` with its low log2(L) bits XORed with k.
- R7: In full-page mode, beat k is (start + k) mod 256, and the burst runs until it is stopped or restarted. Interleave order has no effect here. `col_last` never goes high.
- R8: `col_last` is high only on beat L-1 of a fixed burst. Unless a command arrives in that cycle, `col_valid` is low in the next cycle.
- R9: When `burst_stop` is high in a burst cycle with no command, `col_valid` is low from the next cycle. If a command is present in the same cycle, the command wins.
- R10: A command in any cycle of a running burst restarts generation. The next cycle shows beat 0 at the new start column, with the length and ordering of the current mode.
- R11: When the single-write option is on, a write is one beat with `col_last` high, while reads still use the programmed length. If `rd_cmd` and `wr_cmd` are both high, the command is treated as a read.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| rst_n | input | 1 | Asynchronous reset, active low |
| mrs_stb | input | 1 | Load the mode from `mrs_addr` |
| mrs_addr | input | ADDR_W (11) | Address bus carrying the mode fields |
| rd_cmd | input | 1 | Read column command |
| wr_cmd | input | 1 | Write column command |
| start_col | input | COL_W (8) | Start column of the command |
| burst_stop | input | 1 | End the running burst |
| col_addr | output | COL_W (8) | Column of the current beat |
| col_valid | output | 1 | A beat is present |
| col_last | output | 1 | Final beat of a fixed-length burst |
| cas_lat | output | 3 | Stored CAS latency code |
| mode_err | output | 1 | The last mode load was rejected |

## Verification
Mode fields and `mode_err` are due one cycle after the strobe edge. Beat 0 is due one cycle after the command edge, and beat k follows k cycles later. The drop of `col_valid` after a final beat or a stop is due one cycle after that edge. The bench changes inputs on the falling edge and samples on the next falling edge, so each check reads the cycle counted from the edge that took the stimulus. Expected columns come from a bench function written from R5 to R7, not from the design.

// File: rtl/bcg_pkg.sv
package bcg_pkg;

    typedef enum logic [1:0] {
        ST_IDLE,
        ST_FIXED,
        ST_PAGE
    } bcg_state_e;

    localparam logic [2:0] BLEN_PAGE = 3'b111;
    localparam logic [2:0] CAS_TWO   = 3'b010;
    localparam logic [2:0] CAS_THREE = 3'b011;

    typedef struct packed {
        logic       single_wr;
        logic [2:0] cas;
        logic       ilv;
        logic [2:0] blen;
    } bcg_mode_t;

    localparam bcg_mode_t MODE_RESET = '{single_wr: 1'b0, cas: CAS_TWO,
                                         ilv: 1'b0, blen: 3'b000};

endpackage

// File: rtl/bcg_mode_reg.sv
module bcg_mode_reg
    import bcg_pkg::*;
#(
    parameter int ADDR_W = 11
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              load,
    input  logic [ADDR_W-1:0] addr,
    output bcg_mode_t         mode,
    output logic              bad_q
);

    logic hi_bad;
    logic bl_bad;
    logic cl_bad;
    logic tm_bad;
    logic reject;

    generate
        if (ADDR_W > 10) begin : g_hi
            assign hi_bad = |addr[ADDR_W-1:10];
        end else begin : g_nohi
            assign hi_bad = 1'b0;
        end
    endgenerate

    always_comb begin
        bl_bad = addr[2] && (addr[1:0] != 2'b11);
        cl_bad = (addr[6:4] != CAS_TWO) && (addr[6:4] != CAS_THREE);
        tm_bad = |addr[8:7];
        reject = bl_bad || cl_bad || tm_bad || hi_bad;
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            mode  <= MODE_RESET;
            bad_q <= 1'b0;
        end else if (load) begin
            bad_q <= reject;
            if (!reject) begin
                mode <= '{single_wr: addr[9], cas: addr[6:4],
                          ilv: addr[3], blen: addr[2:0]};
            end
        end
    end

    // R3: a load with the test field set leaves the mode untouched
    a_r3_keep_mode: assert property (@(posedge clk) disable iff (!rst_n)
        (load && addr[8:7] != 2'b00) |=> (mode == $past(mode)));

    // R3: a rejected load is visible as an error in the next cycle
    a_r3_flag_bad_cl: assert property (@(posedge clk) disable iff (!rst_n)
        (load && addr[6:4] == 3'b000) |=> bad_q);

endmodule

// File: rtl/bcg_burst_seq.sv
module bcg_burst_seq
    import bcg_pkg::*;
#(
    parameter int COL_W = 8
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic [2:0]       blen,
    input  logic             ilv,
    input  logic             single_wr,
    input  logic             rd_cmd,
    input  logic             wr_cmd,
    input  logic [COL_W-1:0] start_col,
    input  logic             stop,
    output logic [COL_W-1:0] col,
    output logic             col_valid,
    output logic             col_last
);

    bcg_state_e       state_q, state_d;
    logic [COL_W-1:0] base_q, base_d;
    logic [COL_W-1:0] beat_q, beat_d;
    logic [1:0]       lg_q, lg_d;
    logic             ilv_q, ilv_d;
    logic [COL_W-1:0] mask;
    logic             cmd;
    logic             one_beat_wr;
    logic             at_end;

    always_comb begin
        mask        = (COL_W'(1) << lg_q) - COL_W'(1);
        cmd         = rd_cmd || wr_cmd;
        one_beat_wr = wr_cmd && !rd_cmd && single_wr;
        at_end      = (beat_q == mask);
    end

    // next-state selection
    always_comb begin
        state_d = state_q;
        base_d  = base_q;
        beat_d  = beat_q + COL_W'(1);
        lg_d    = lg_q;
        ilv_d   = ilv_q;
        if (cmd) begin
            base_d = start_col;
            beat_d = '0;
            ilv_d  = ilv;
            if (one_beat_wr) begin
                state_d = ST_FIXED;
                lg_d    = 2'd0;
            end else if (blen == BLEN_PAGE) begin
                state_d = ST_PAGE;
                lg_d    = 2'd0;
            end else begin
                state_d = ST_FIXED;
                lg_d    = blen[1:0];
            end
        end else begin
            unique case (state_q)
                ST_IDLE:  beat_d = beat_q;
                ST_FIXED: if (stop || at_end) state_d = ST_IDLE;
                ST_PAGE:  if (stop) state_d = ST_IDLE;
                default:  state_d = ST_IDLE;
            endcase
        end
    end

    // state register
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            state_q <= ST_IDLE;
            base_q  <= '0;
            beat_q  <= '0;
            lg_q    <= 2'd0;
            ilv_q   <= 1'b0;
        end else begin
            state_q <= state_d;
            base_q  <= base_d;
            beat_q  <= beat_d;
            lg_q    <= lg_d;
            ilv_q   <= ilv_d;
        end
    end

    // outputs
    always_comb begin
        col_valid = 1'b0;
        col_last  = 1'b0;
        col       = base_q;
        unique case (state_q)
            ST_IDLE: ;
            ST_FIXED: begin
                col_valid = 1'b1;
                col_last  = at_end;
                if (ilv_q) col = base_q ^ (beat_q & mask);
                else       col = (base_q & ~mask) | ((base_q + beat_q) & mask);
            end
            ST_PAGE: begin
                col_valid = 1'b1;
                col       = base_q + beat_q;
            end
            default: ;
        endcase
    end

    // R4: beat 0 of every burst is the commanded column
    a_r4_first_beat: assert property (@(posedge clk) disable iff (!rst_n)
        (rd_cmd || wr_cmd) |=> (col_valid && col == $past(start_col)));

    // R7: a full-page burst advances by one column per cycle and never flags last
    a_r7_page_step: assert property (@(posedge clk) disable iff (!rst_n)
        (state_q == ST_PAGE && !rd_cmd && !wr_cmd && !stop)
            |=> (col == COL_W'($past(col) + COL_W'(1)) && !col_last));

    // R8: a non-final beat is followed by another beat
    a_r8_continue: assert property (@(posedge clk) disable iff (!rst_n)
        (col_valid && !col_last && !rd_cmd && !wr_cmd && !stop) |=> col_valid);

    // R8: the final beat ends the burst
    a_r8_end: assert property (@(posedge clk) disable iff (!rst_n)
        (col_last && !rd_cmd && !wr_cmd) |=> !col_valid);

    // R9: stop without a command ends the burst
    a_r9_stop: assert property (@(posedge clk) disable iff (!rst_n)
        (stop && !rd_cmd && !wr_cmd) |=> !col_valid);

endmodule

// File: rtl/sdr_burst_colgen.sv
module sdr_burst_colgen
    import bcg_pkg::*;
#(
    parameter int ADDR_W = 11,
    parameter int COL_W  = 8
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              mrs_stb,
    input  logic [ADDR_W-1:0] mrs_addr,
    input  logic              rd_cmd,
    input  logic              wr_cmd,
    input  logic [COL_W-1:0]  start_col,
    input  logic              burst_stop,
    output logic [COL_W-1:0]  col_addr,
    output logic              col_valid,
    output logic              col_last,
    output logic [2:0]        cas_lat,
    output logic              mode_err
);

    bcg_mode_t mode;

    bcg_mode_reg #(.ADDR_W(ADDR_W)) u_mode (
        .clk   (clk),
        .rst_n (rst_n),
        .load  (mrs_stb),
        .addr  (mrs_addr),
        .mode  (mode),
        .bad_q (mode_err)
    );

    bcg_burst_seq #(.COL_W(COL_W)) u_seq (
        .clk       (clk),
        .rst_n     (rst_n),
        .blen      (mode.blen),
        .ilv       (mode.ilv),
        .single_wr (mode.single_wr),
        .rd_cmd    (rd_cmd),
        .wr_cmd    (wr_cmd),
        .start_col (start_col),
        .stop      (burst_stop),
        .col       (col_addr),
        .col_valid (col_valid),
        .col_last  (col_last)
    );

    assign cas_lat = mode.cas;

endmodule

// File: tb/sdr_burst_colgen_test.sv
module sdr_burst_colgen_test;

    typedef struct packed {
        logic [10:0] mode;
        logic        wr;
        logic [7:0]  col;
    } vec_t;

    localparam int NVEC = 9;
    localparam vec_t VEC [0:NVEC-1] = '{
        '{11'h022, 1'b0, 8'h06},
        '{11'h033, 1'b0, 8'h0D},
        '{11'h02B, 1'b0, 8'h0D},
        '{11'h02A, 1'b1, 8'h02},
        '{11'h021, 1'b0, 8'hFF},
        '{11'h020, 1'b0, 8'h55},
        '{11'h233, 1'b1, 8'h10},
        '{11'h233, 1'b0, 8'h10},
        '{11'h029, 1'b0, 8'h81}
    };

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        mrs_stb = 1'b0;
    logic [10:0] mrs_addr = '0;
    logic        rd_cmd = 1'b0;
    logic        wr_cmd = 1'b0;
    logic [7:0]  start_col = '0;
    logic        burst_stop = 1'b0;
    logic [7:0]  col_addr;
    logic        col_valid;
    logic        col_last;
    logic [2:0]  cas_lat;
    logic        mode_err;

    int checks = 0;
    int errors = 0;

    sdr_burst_colgen uut (
        .clk(clk), .rst_n(rst_n), .mrs_stb(mrs_stb), .mrs_addr(mrs_addr),
        .rd_cmd(rd_cmd), .wr_cmd(wr_cmd), .start_col(start_col),
        .burst_stop(burst_stop), .col_addr(col_addr), .col_valid(col_valid),
        .col_last(col_last), .cas_lat(cas_lat), .mode_err(mode_err)
    );

    always #5 clk = ~clk;

    task automatic chk(input string tag, input int act, input int exp);
        checks++;
        if (act != exp) begin
            errors++;
            $display("FAIL %s: actual=%0h expected=%0h", tag, act, exp);
        end
    endtask

    task automatic step();
        @(negedge clk);
    endtask

    task automatic do_mrs(input logic [10:0] m);
        mrs_addr = m;
        mrs_stb  = 1'b1;
        step();
        mrs_stb  = 1'b0;
    endtask

    task automatic issue(input logic wr, input logic [7:0] s);
        rd_cmd    = !wr;
        wr_cmd    = wr;
        start_col = s;
        step();
        rd_cmd = 1'b0;
        wr_cmd = 1'b0;
    endtask

    function automatic logic [7:0] exp_col(input logic [2:0] bl, input logic ord,
                                           input logic [7:0] s, input int k);
        logic [7:0] m;
        logic [7:0] kk;
        kk = 8'(k);
        if (bl == 3'b111) return s + kk;
        m = (8'd1 << bl[1:0]) - 8'd1;
        if (ord) return s ^ (kk & m);
        return (s & ~m) | ((s + kk) & m);
    endfunction

    initial begin
        #2_000_000;
        errors++;
        checks++;
        $display("FAIL watchdog: actual=timeout expected=finish");
        $display("Result: errors=%0d of %0d checks", errors, checks);
        $finish;
    end

    initial begin
        step();
        step();
        rst_n = 1'b1;
        step();
        // R1 reset state
        chk("R1 col_valid", col_valid, 0);
        chk("R1 col_last", col_last, 0);
        chk("R1 mode_err", mode_err, 0);
        chk("R1 cas_lat", cas_lat, 3'b010);
        issue(1'b0, 8'h33);
        chk("R1 default single beat col", col_addr, 8'h33);
        chk("R1 default single beat last", col_last, 1);
        step();
        chk("R1 default burst ends", col_valid, 0);

        // vector table
        for (int i = 0; i < NVEC; i++) begin
            logic [2:0] bl;
            logic       ord;
            int         len;
            string      tag;
            bl  = VEC[i].mode[2:0];
            ord = VEC[i].mode[3];
            do_mrs(VEC[i].mode);
            chk("R2 cas_lat", cas_lat, VEC[i].mode[6:4]);
            chk("R3 valid load no error", mode_err, 0);
            len = 1 << bl[1:0];
            if (VEC[i].wr && VEC[i].mode[9]) begin
                len = 1;
                tag = "R11";
            end else if (ord) tag = "R6";
            else tag = "R5";
            issue(VEC[i].wr, VEC[i].col);
            for (int k = 0; k < len; k++) begin
                chk({"R4 valid ", tag}, col_valid, 1);
                chk({tag, " column"}, col_addr,
                    (len == 1) ? VEC[i].col : exp_col(bl, ord, VEC[i].col, k));
                chk({"R8 last ", tag}, col_last, (k == len - 1) ? 1 : 0);
                step();
            end
            chk("R8 valid drops after last", col_valid, 0);
        end

        // R7 full page with wrap, then R9 stop
        do_mrs(11'h037);
        chk("R2 cas_lat page", cas_lat, 3);
        issue(1'b0, 8'hFC);
        for (int k = 0; k < 260; k++) begin
            chk("R7 page column", col_addr, 8'(8'hFC + k));
            chk("R7 page no last", col_last, 0);
            chk("R7 page valid", col_valid, 1);
            step();
        end
        burst_stop = 1'b1;
        step();
        burst_stop = 1'b0;
        chk("R9 stop ends page", col_valid, 0);

        // R9 stop in fixed burst
        do_mrs(11'h033);
        issue(1'b0, 8'h20);
        step();
        step();
        chk("R9 mid burst col", col_addr, 8'h22);
        burst_stop = 1'b1;
        step();
        burst_stop = 1'b0;
        chk("R9 stop ends fixed", col_valid, 0);

        // R9 stop together with command: command wins
        issue(1'b0, 8'h20);
        step();
        burst_stop = 1'b1;
        rd_cmd     = 1'b1;
        start_col  = 8'h70;
        step();
        burst_stop = 1'b0;
        rd_cmd     = 1'b0;
        chk("R9 command wins valid", col_valid, 1);
        chk("R9 command wins col", col_addr, 8'h70);
        for (int k = 0; k < 7; k++) step();
        chk("R8 last after restart", col_last, 1);
        chk("R8 last col after restart", col_addr, 8'h77);
        step();
        chk("R8 ends after restart", col_valid, 0);

        // R10 restart mid burst
        issue(1'b0, 8'h00);
        step();
        step();
        chk("R10 before restart", col_addr, 8'h02);
        issue(1'b0, 8'h43);
        chk("R10 restart col", col_addr, 8'h43);
        chk("R10 restart last", col_last, 0);
        step();
        chk("R10 restart next col", col_addr, 8'h44);
        for (int k = 0; k < 7; k++) step();
        chk("R10 restart burst done", col_valid, 0);

        // R3 reserved loads keep the mode (CL3, BL8 sequential)
        do_mrs(11'h024);
        chk("R3 reserved length err", mode_err, 1);
        chk("R3 reserved length cas kept", cas_lat, 3);
        do_mrs(11'h052);
        chk("R3 reserved cas err", mode_err, 1);
        chk("R3 reserved cas kept", cas_lat, 3);
        do_mrs(11'h1A2);
        chk("R3 test bits err", mode_err, 1);
        do_mrs(11'h422);
        chk("R3 high bit err", mode_err, 1);
        chk("R3 high bit cas kept", cas_lat, 3);
        issue(1'b0, 8'h00);
        for (int k = 0; k < 7; k++) step();
        chk("R3 length kept col", col_addr, 8'h07);
        chk("R3 length kept last", col_last, 1);
        step();
        do_mrs(11'h022);
        chk("R3 valid load clears err", mode_err, 0);
        chk("R3 valid load cas", cas_lat, 2);

        // R11 both commands high counts as read
        do_mrs(11'h232);
        rd_cmd = 1'b1;
        wr_cmd = 1'b1;
        start_col = 8'h08;
        step();
        rd_cmd = 1'b0;
        wr_cmd = 1'b0;
        chk("R11 dual command not single", col_last, 0);
        step();
        step();
        step();
        chk("R11 dual command read length", col_last, 1);
        step();

        $display("Result: errors=%0d of %0d checks", errors, checks);
        $finish;
    end

endmodule